// File: doc/BRIEF.md
# Program Memory Mode and Arbitration Controller

This block sits in front of an on-chip program memory built from two single-port RAM banks of 32K 32-bit words each. A three-bit mode field in a control word, written by the CPU, chooses between a mapped mode and a cache mode. In mapped mode both banks are plain addressable RAM, placed one above the other. In cache mode bank 1 is handed over to cache storage and only bank 0 stays addressable. A static pin chooses one of two memory maps for the address windows.

The block decodes every CPU and DMA access against the active map and mode. It steers each access to the right bank with a fixed CPU-first rule, and it answers accesses that hit no live bank with an undefined-result flag. It runs a fixed-length cache flush whenever the mode changes or a flush is requested. During a flush the CPU is frozen and DMA traffic to bank 0 carries on. Entry into cache mode is held back until no DMA access to bank 1 is still outstanding.

The RAM arrays, the cache lookup logic and the CPU sit outside the block. They connect through request, grant and ready signals and through plain bank ports with one cycle of read latency.

Top module: `pmem_mode_ctrl`

## Requirements
- R1: After reset the applied mode is 000 (mapped). `cache_active`, `flush_busy`, `flush_done`, both grants and both ready outputs are low.
- R2: CPU and DMA addresses are decoded the same way. Under `map_sel`=0, bank 0 is 0x0140_0000–0x0141_FFFF and bank 1 is 0x0142_0000–0x0143_FFFF. Under `map_sel`=1, bank 0 is 0x0000_0000–0x0001_FFFF and bank 1 is 0x0002_0000–0x0003_FFFF. The bank word address is byte address bits 16:2. Any other address is undefined.
- R3: With mode 010 (cache) applied, an access to the bank 1 window is granted without enabling bank 1. It completes with the undefined flag set and read data of zero. Bank 0 stays reachable at its window.
- R4: When the CPU and the DMA request the same bank in one cycle, the CPU is granted and the DMA grant stays low. A held DMA request is granted in the first cycle the CPU leaves that bank.
- R5: While `flush_busy` is high, `cpu_gnt` stays low for any address.
- R6: While `flush_busy` is high, a DMA request to bank 0 with no CPU contention is granted in the same cycle.
- R7: A flush starts on the clock edge that applies a new mode, or on the edge that samples `flush_req` high. `flush_busy` is then high for exactly FLUSH_LINES cycles, followed by a one-cycle `flush_done` pulse.
- R8: A control write whose bits 7:5 are 010 becomes the applied mode only on an edge where `dma_b1_pending` is zero. Until then `mode_o` and `cache_active` keep their old values.
- R9: An access granted in cycle t raises that port's ready in cycle t+1. The read data in that cycle is the selected bank's read data. For a write the bank sees write enable, word address and data in cycle t.
- R10: A control write whose bits 7:5 select a mode other than cache is applied on the edge that samples it, and shows on `mode_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sel | input | 1 | Static memory map select |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bits 7:5 carry the mode |
| flush_req | input | 1 | Explicit flush request |
| dma_b1_pending | input | 8 | Outstanding DMA accesses to bank 1 |
| mode_o | output | 3 | Applied mode field |
| cache_active | output | 1 | Cache mode is applied |
| flush_busy | output | 1 | Flush in progress |
| flush_done | output | 1 | One-cycle flush completion pulse |
| cpu_req | input | 1 | CPU request |
| cpu_we | input | 1 | CPU write |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_gnt | output | 1 | CPU grant |
| cpu_rdy | output | 1 | CPU response valid |
| cpu_undef | output | 1 | CPU response is undefined |
| cpu_rdata | output | 32 | CPU read data |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write |
| dma_addr | input | 32 | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_gnt | output | 1 | DMA grant |
| dma_rdy | output | 1 | DMA response valid |
| dma_undef | output | 1 | DMA response is undefined |
| dma_rdata | output | 32 | DMA read data |
| b0_en | output | 1 | Bank 0 enable |
| b0_we | output | 1 | Bank 0 write enable |
| b0_addr | output | 15 | Bank 0 word address |
| b0_wdata | output | 32 | Bank 0 write data |
| b0_rdata | input | 32 | Bank 0 read data, one cycle after enable |
| b1_en | output | 1 | Bank 1 enable |
| b1_we | output | 1 | Bank 1 write enable |
| b1_addr | output | 15 | Bank 1 word address |
| b1_wdata | output | 32 | Bank 1 write data |
| b1_rdata | input | 32 | Bank 1 read data, one cycle after enable |

## Verification
A wrong applied mode shows on the next access to the bank 1 window. That access either enables bank 1 in its grant cycle or fails to raise the undefined flag one cycle later. A flush counter that is off by even one cycle shows as a `flush_busy` run of the wrong length and a misplaced `flush_done` pulse. A bad arbitration decision shows at once as a wrong grant or a bank address taken from the losing port, in the same cycle as the request. A bad response register shows one cycle later as ready, flag or data on the wrong port.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    localparam int BANK_AW   = 15;            // word address bits per bank
    localparam int BANK_SPAN = BANK_AW + 2;   // byte address bits per bank
    localparam int BLK_W     = 32 - BANK_SPAN;
    localparam int MODE_LSB  = 5;
    localparam int MODE_W    = 3;

    localparam logic [MODE_W-1:0] MODE_MAPPED = 3'b000;
    localparam logic [MODE_W-1:0] MODE_CACHE  = 3'b010;

    localparam logic [31:0] MAP0_BASE = 32'h0140_0000;
    localparam logic [31:0] MAP1_BASE = 32'h0000_0000;

    typedef enum logic [1:0] {
        RGN_B0    = 2'd0,
        RGN_B1    = 2'd1,
        RGN_UNDEF = 2'd2
    } rgn_e;

    typedef struct packed {
        logic rdy;
        logic undef;
        logic bank;
    } rsp_t;

    function automatic rgn_e decode_rgn(input logic [31:0] a, input logic map,
                                        input logic cache);
        logic [BLK_W-1:0] blk;
        logic [BLK_W-1:0] base;
        blk  = a[31:BANK_SPAN];
        base = map ? MAP1_BASE[31:BANK_SPAN] : MAP0_BASE[31:BANK_SPAN];
        if (blk == base)
            return RGN_B0;
        if (blk == base + BLK_W'(1))
            return cache ? RGN_UNDEF : RGN_B1;
        return RGN_UNDEF;
    endfunction

endpackage

// File: rtl/pmem_mode_ctl.sv
module pmem_mode_ctl
    import pmem_pkg::*;
#(
    parameter int FLUSH_LINES = 64,
    parameter int PEND_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              flush_req,
    input  logic [PEND_W-1:0] b1_pending,
    output logic [MODE_W-1:0] mode_o,
    output logic              cache_active,
    output logic              flush_busy,
    output logic              flush_done
);

    localparam int CW = $clog2(FLUSH_LINES + 1);

    logic [MODE_W-1:0] want_q, want_n, mode_q;
    logic [CW-1:0]     cnt_q;
    logic              apply;

    always_comb begin
        want_n = ctl_we ? ctl_mode : want_q;
        apply  = (want_n != mode_q) &&
                 ((want_n != MODE_CACHE) || (b1_pending == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            want_q     <= MODE_MAPPED;
            mode_q     <= MODE_MAPPED;
            flush_busy <= 1'b0;
            flush_done <= 1'b0;
            cnt_q      <= '0;
        end else begin
            want_q     <= want_n;
            flush_done <= 1'b0;
            if (apply)
                mode_q <= want_n;
            if (apply || flush_req) begin
                flush_busy <= 1'b1;
                cnt_q      <= CW'(FLUSH_LINES - 1);
            end else if (flush_busy) begin
                if (cnt_q == '0) begin
                    flush_busy <= 1'b0;
                    flush_done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign mode_o       = mode_q;
    assign cache_active = (mode_q == MODE_CACHE);

    assert_enter_cache_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cache_active) |-> ($past(b1_pending) == '0));

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> ($past(flush_busy) && !flush_busy));

endmodule

// File: rtl/pmem_bank_arb.sv
module pmem_bank_arb (
    input  logic cpu_hit,
    input  logic dma_hit,
    output logic cpu_win,
    output logic dma_win
);
    always_comb begin
        cpu_win = cpu_hit;
        dma_win = dma_hit && !cpu_hit;
    end
endmodule

// File: rtl/pmem_mode_ctrl.sv
module pmem_mode_ctrl
    import pmem_pkg::*;
#(
    parameter int FLUSH_LINES = 64,
    parameter int PEND_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               map_sel,
    input  logic               ctl_we,
    input  logic [31:0]        ctl_wdata,
    input  logic               flush_req,
    input  logic [PEND_W-1:0]  dma_b1_pending,
    output logic [MODE_W-1:0]  mode_o,
    output logic               cache_active,
    output logic               flush_busy,
    output logic               flush_done,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [31:0]        cpu_addr,
    input  logic [31:0]        cpu_wdata,
    output logic               cpu_gnt,
    output logic               cpu_rdy,
    output logic               cpu_undef,
    output logic [31:0]        cpu_rdata,
    input  logic               dma_req,
    input  logic               dma_we,
    input  logic [31:0]        dma_addr,
    input  logic [31:0]        dma_wdata,
    output logic               dma_gnt,
    output logic               dma_rdy,
    output logic               dma_undef,
    output logic [31:0]        dma_rdata,
    output logic               b0_en,
    output logic               b0_we,
    output logic [BANK_AW-1:0] b0_addr,
    output logic [31:0]        b0_wdata,
    input  logic [31:0]        b0_rdata,
    output logic               b1_en,
    output logic               b1_we,
    output logic [BANK_AW-1:0] b1_addr,
    output logic [31:0]        b1_wdata,
    input  logic [31:0]        b1_rdata
);

    localparam int NBANK = 2;

    rgn_e cpu_rgn, dma_rgn;
    logic cpu_live;
    logic [NBANK-1:0] cpu_hit, dma_hit, cpu_win, dma_win;
    logic [NBANK-1:0] bk_en, bk_we;
    logic [BANK_AW-1:0] bk_addr [NBANK];
    logic [31:0]        bk_wdata [NBANK];
    rsp_t cpu_rsp_q, dma_rsp_q;
    logic unused_bits;

    pmem_mode_ctl #(.FLUSH_LINES(FLUSH_LINES), .PEND_W(PEND_W)) u_mode (
        .clk         (clk),
        .rst         (rst),
        .ctl_we      (ctl_we),
        .ctl_mode    (ctl_wdata[MODE_LSB +: MODE_W]),
        .flush_req   (flush_req),
        .b1_pending  (dma_b1_pending),
        .mode_o      (mode_o),
        .cache_active(cache_active),
        .flush_busy  (flush_busy),
        .flush_done  (flush_done)
    );

    always_comb begin
        cpu_rgn  = decode_rgn(cpu_addr, map_sel, cache_active);
        dma_rgn  = decode_rgn(dma_addr, map_sel, cache_active);
        cpu_live = cpu_req && !flush_busy;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign cpu_hit[b] = cpu_live && (cpu_rgn == rgn_e'(2'(b)));
        assign dma_hit[b] = dma_req  && (dma_rgn == rgn_e'(2'(b)));

        pmem_bank_arb u_arb (
            .cpu_hit(cpu_hit[b]),
            .dma_hit(dma_hit[b]),
            .cpu_win(cpu_win[b]),
            .dma_win(dma_win[b])
        );

        assign bk_en[b]    = cpu_win[b] || dma_win[b];
        assign bk_we[b]    = cpu_win[b] ? cpu_we : (dma_win[b] && dma_we);
        assign bk_addr[b]  = cpu_win[b] ? cpu_addr[BANK_SPAN-1:2] : dma_addr[BANK_SPAN-1:2];
        assign bk_wdata[b] = cpu_win[b] ? cpu_wdata : dma_wdata;
    end

    assign {b1_en, b0_en} = bk_en;
    assign {b1_we, b0_we} = bk_we;
    assign b0_addr  = bk_addr[0];
    assign b1_addr  = bk_addr[1];
    assign b0_wdata = bk_wdata[0];
    assign b1_wdata = bk_wdata[1];

    assign cpu_gnt = cpu_live && ((cpu_rgn == RGN_UNDEF) || (|cpu_win));
    assign dma_gnt = dma_req  && ((dma_rgn == RGN_UNDEF) || (|dma_win));

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rsp_q <= '0;
            dma_rsp_q <= '0;
        end else begin
            cpu_rsp_q <= '{rdy: cpu_gnt, undef: cpu_gnt && (cpu_rgn == RGN_UNDEF),
                           bank: cpu_win[1]};
            dma_rsp_q <= '{rdy: dma_gnt, undef: dma_gnt && (dma_rgn == RGN_UNDEF),
                           bank: dma_win[1]};
        end
    end

    assign cpu_rdy   = cpu_rsp_q.rdy;
    assign cpu_undef = cpu_rsp_q.rdy && cpu_rsp_q.undef;
    assign cpu_rdata = (!cpu_rsp_q.rdy || cpu_rsp_q.undef) ? '0 :
                       (cpu_rsp_q.bank ? b1_rdata : b0_rdata);
    assign dma_rdy   = dma_rsp_q.rdy;
    assign dma_undef = dma_rsp_q.rdy && dma_rsp_q.undef;
    assign dma_rdata = (!dma_rsp_q.rdy || dma_rsp_q.undef) ? '0 :
                       (dma_rsp_q.bank ? b1_rdata : b0_rdata);

    assign unused_bits = ^{ctl_wdata[31:MODE_LSB+MODE_W], ctl_wdata[MODE_LSB-1:0],
                           cpu_addr[1:0], dma_addr[1:0]};

    assert_cpu_first_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req && !flush_busy && cpu_rgn == RGN_B0 && dma_rgn == RGN_B0)
        |-> (cpu_gnt && !dma_gnt));

    assert_flush_stall_R5: assert property (@(posedge clk) disable iff (rst)
        flush_busy |-> !cpu_gnt);

    assert_dma_flows_R6: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && dma_req && dma_rgn == RGN_B0) |-> dma_gnt);

    assert_bank1_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        cache_active |-> !b1_en);

    assert_rdy_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt |=> cpu_rdy) and (dma_gnt |=> dma_rdy));

endmodule

// File: tb/test_pmem_mode_ctrl.sv
module test_pmem_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 64;

    typedef struct packed {
        logic        map;
        logic [31:0] addr;
        logic [1:0]  rgn;   // 0 bank0, 1 bank1, 2 undefined
        logic [14:0] off;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0140_0000, 2'd0, 15'h0000},
        '{1'b0, 32'h0141_FFFC, 2'd0, 15'h7FFF},
        '{1'b0, 32'h0142_0000, 2'd1, 15'h0000},
        '{1'b0, 32'h0143_FFFC, 2'd1, 15'h7FFF},
        '{1'b0, 32'h0144_0000, 2'd2, 15'h0000},
        '{1'b0, 32'h0000_0010, 2'd2, 15'h0000},
        '{1'b1, 32'h0000_0008, 2'd0, 15'h0002},
        '{1'b1, 32'h0002_0004, 2'd1, 15'h0001},
        '{1'b1, 32'h0140_0000, 2'd2, 15'h0000},
        '{1'b1, 32'h0003_FFFC, 2'd1, 15'h7FFF}
    };

    logic clk = 1'b0, rst = 1'b1, map_sel = 1'b0;
    logic ctl_we = 1'b0, flush_req = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [7:0]  dma_b1_pending = '0;
    logic [2:0]  mode_o;
    logic cache_active, flush_busy, flush_done;
    logic cpu_req = 1'b0, cpu_we = 1'b0, dma_req = 1'b0, dma_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, dma_addr = '0, dma_wdata = '0;
    logic cpu_gnt, cpu_rdy, cpu_undef, dma_gnt, dma_rdy, dma_undef;
    logic [31:0] cpu_rdata, dma_rdata;
    logic b0_en, b0_we, b1_en, b1_we;
    logic [14:0] b0_addr, b1_addr;
    logic [31:0] b0_wdata, b1_wdata;
    logic [31:0] b0_rdata = '0, b1_rdata = '0;

    int ntest = 0, nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // bank models: one cycle read latency, data tagged with bank and word address
    always @(posedge clk) begin
        b0_rdata <= {8'hB0, 9'h0, b0_addr};
        b1_rdata <= {8'hB1, 9'h0, b1_addr};
    end

    pmem_mode_ctrl #(.FLUSH_LINES(LINES), .PEND_W(8)) i_pmem_mode_ctrl (
        .clk(clk), .rst(rst), .map_sel(map_sel), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .flush_req(flush_req), .dma_b1_pending(dma_b1_pending), .mode_o(mode_o),
        .cache_active(cache_active), .flush_busy(flush_busy), .flush_done(flush_done),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_rdy(cpu_rdy), .cpu_undef(cpu_undef), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_gnt(dma_gnt), .dma_rdy(dma_rdy), .dma_undef(dma_undef), .dma_rdata(dma_rdata),
        .b0_en(b0_en), .b0_we(b0_we), .b0_addr(b0_addr), .b0_wdata(b0_wdata), .b0_rdata(b0_rdata),
        .b1_en(b1_en), .b1_we(b1_we), .b1_addr(b1_addr), .b1_wdata(b1_wdata), .b1_rdata(b1_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [2:0] m);
        ctl_wdata = {24'h0, m, 5'h0};
        ctl_we    = 1'b1;
        step();
        ctl_we    = 1'b0;
    endtask

    task automatic wait_flush_end();
        while (flush_busy) step();
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 mode", 32'(mode_o), 32'h0);
        chk("R1 idle", {28'h0, cache_active, flush_busy, flush_done, cpu_rdy},
            32'h0);
        chk("R1 grants", {30'h0, cpu_gnt, dma_gnt}, 32'h0);

        // R2/R9 mapped-mode decode table
        foreach (VECS[i]) begin
            map_sel  = VECS[i].map;
            cpu_addr = VECS[i].addr;
            cpu_req  = 1'b1;
            #1;
            chk("R2 gnt", 32'(cpu_gnt), 32'h1);
            chk("R2 enables", {30'h0, b1_en, b0_en},
                (VECS[i].rgn == 2'd0) ? 32'h1 : (VECS[i].rgn == 2'd1) ? 32'h2 : 32'h0);
            if (VECS[i].rgn == 2'd0) chk("R2 b0_addr", 32'(b0_addr), 32'(VECS[i].off));
            if (VECS[i].rgn == 2'd1) chk("R2 b1_addr", 32'(b1_addr), 32'(VECS[i].off));
            step();
            cpu_req = 1'b0;
            #1;
            chk("R9 rdy", {30'h0, cpu_rdy, cpu_undef}, (VECS[i].rgn == 2'd2) ? 32'h3 : 32'h2);
            chk("R9 rdata", cpu_rdata,
                (VECS[i].rgn == 2'd0) ? {8'hB0, 9'h0, VECS[i].off} :
                (VECS[i].rgn == 2'd1) ? {8'hB1, 9'h0, VECS[i].off} : 32'h0);
        end

        // R4 contention on bank 0, DMA held until CPU leaves
        map_sel  = 1'b0;
        cpu_addr = 32'h0140_0010; cpu_req = 1'b1;
        dma_addr = 32'h0140_0020; dma_req = 1'b1;
        #1;
        chk("R4 cpu wins", {30'h0, cpu_gnt, dma_gnt}, 32'h2);
        chk("R4 b0 addr cpu", 32'(b0_addr), 32'h4);
        step();
        cpu_req = 1'b0;
        #1;
        chk("R4 dma served", 32'(dma_gnt), 32'h1);
        chk("R4 b0 addr dma", 32'(b0_addr), 32'h8);
        step();
        dma_req = 1'b0;
        #1;
        chk("R9 dma rdata", dma_rdata, {8'hB0, 9'h0, 15'h8});

        // R9 CPU write to bank 1
        cpu_addr = 32'h0142_0040; cpu_we = 1'b1; cpu_wdata = 32'hCAFE_0001; cpu_req = 1'b1;
        #1;
        chk("R9 write strobe", {30'h0, b1_en, b1_we}, 32'h3);
        chk("R9 write data", b1_wdata, 32'hCAFE_0001);
        step();
        cpu_req = 1'b0; cpu_we = 1'b0;

        // R7 explicit flush, R5 CPU stall, R6 DMA flow
        flush_req = 1'b1;
        step();
        flush_req = 1'b0;
        cpu_addr = 32'h0140_0000; cpu_req = 1'b1;
        dma_addr = 32'h0140_0004; dma_req = 1'b1;
        #1;
        chk("R5 cpu stalled", 32'(cpu_gnt), 32'h0);
        chk("R6 dma granted", 32'(dma_gnt), 32'h1);
        chk("R6 b0 addr dma", 32'(b0_addr), 32'h1);
        n = 0;
        while (flush_busy) begin
            if (cpu_gnt) chk("R5 cpu gnt during flush", 32'h1, 32'h0);
            n++;
            step();
        end
        chk("R7 flush length", 32'(n), 32'(LINES));
        chk("R7 done pulse", 32'(flush_done), 32'h1);
        cpu_req = 1'b0; dma_req = 1'b0;
        step();
        chk("R7 done one cycle", 32'(flush_done), 32'h0);

        // R8 cache entry waits for DMA pending on bank 1
        dma_b1_pending = 8'd3;
        write_mode(3'b010);
        repeat (4) step();
        chk("R8 held mode", 32'(mode_o), 32'h0);
        chk("R8 held cache", {30'h0, cache_active, flush_busy}, 32'h0);
        dma_b1_pending = 8'd0;
        step();
        chk("R8 applied", {28'h0, cache_active, mode_o}, 32'hA);
        chk("R7 mode flush", 32'(flush_busy), 32'h1);
        wait_flush_end();

        // R3 cache mode: bank 1 window undefined, bank 0 live
        cpu_addr = 32'h0142_0000; cpu_req = 1'b1;
        #1;
        chk("R3 cpu gnt", {30'h0, cpu_gnt, b1_en}, 32'h2);
        step();
        cpu_req = 1'b0;
        #1;
        chk("R3 cpu undef", {30'h0, cpu_rdy, cpu_undef}, 32'h3);
        chk("R3 cpu rdata", cpu_rdata, 32'h0);
        dma_addr = 32'h0143_0000; dma_req = 1'b1;
        #1;
        chk("R3 dma gnt", {30'h0, dma_gnt, b1_en}, 32'h2);
        step();
        dma_req = 1'b0;
        #1;
        chk("R3 dma undef", {30'h0, dma_rdy, dma_undef}, 32'h3);
        cpu_addr = 32'h0140_0004; cpu_req = 1'b1;
        #1;
        chk("R3 bank0 live", {30'h0, b0_en, b1_en}, 32'h2);
        chk("R3 bank0 addr", 32'(b0_addr), 32'h1);
        step();
        cpu_req = 1'b0;
        #1;
        chk("R3 bank0 rdata", cpu_rdata, {8'hB0, 9'h0, 15'h1});

        // R10 leaving cache mode is immediate
        dma_b1_pending = 8'd5;
        write_mode(3'b000);
        chk("R10 mode", {28'h0, cache_active, mode_o}, 32'h0);
        chk("R10 flush", 32'(flush_busy), 32'h1);
        dma_b1_pending = 8'd0;
        wait_flush_end();

        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

endmodule